// File: doc/BRIEF.md
# PHY Configuration I2C Command Master

This block configures a transmitter PHY over a two-wire serial link. Software reaches it through a byte-wide register bus with 16-bit offsets. It loads a 7-bit device address, an 8-bit PHY register index and a 16-bit data word, then writes an operation byte to launch one transaction. A write moves the register index and both data bytes to the PHY. A read sends the register index, turns the bus round with a repeated START and gathers two bytes back.

Each transaction ends by setting exactly one of two sticky status flags: one for completion and one for failure. A failure is any byte that the PHY leaves unacknowledged. Software clears a flag by writing one to its position. A mute register blocks each flag from the interrupt line on its own. The SCL rate is set by a parameterised divider. SDA moves only while SCL is low, except at START and STOP.

Top module: `phy_i2c_cmd_master`

## Requirements
- R1: After reset SCL is released high, SDA is not pulled low, the status and mute registers read 0 and `irq` is low.
- R2: The device address (0x3020), register index (0x3021), data high byte (0x3022) and data low byte (0x3023) read back what was written. The operation register (0x3026) reads 0.
- R3: Writing 1 to bit 1 of 0x3026 while idle runs a write: START, (device address << 1) with bit 0 = 0, register index, data high byte, data low byte, STOP. The frame has one START.
- R4: Writing 1 to bit 0 of 0x3026 while idle runs a read: START, (device address << 1) with bit 0 = 0, register index, repeated START, (device address << 1) with bit 0 = 1, then two bytes in. The master ACKs the first byte and NACKs the second, then sends STOP. The first byte is readable at 0x3024 and the second at 0x3025.
- R5: Every transaction ends with exactly one of status bit 1 (done) or status bit 0 (error) of 0x0108 being set, and only once the bus is idle again.
- R6: A NACK on any byte the master sends ends the frame with STOP and sets the error bit, not the done bit.
- R7: Status bits are sticky. Writing 1 to a bit position of 0x0108 clears that bit and writing 0 leaves it. A set event in the same cycle as a clear wins.
- R8: The mute register at 0x0188 uses the same bit positions as the status register. `irq` is high exactly when some status bit is set whose mute bit is clear.
- R9: A start request written while a transaction is in progress is ignored: no second frame follows and the running frame keeps its direction.
- R10: SDA changes while SCL is high only for a START (falling SDA) or a STOP (rising SDA).
- R11: Each bit lasts 4*CLK_DIV clock cycles, of which SCL is high for 2*CLK_DIV.
- R12: If both operation bits are written as 1 together, a write is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Register offset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| scl_o | output | 1 | SCL level (1 = released) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Sensed SDA level |
| irq | output | 1 | Unmuted status present |

## Verification
The bench builds the block with CLK_DIV = 2, so a phase lasts two cycles and a bit lasts eight. This keeps a full read frame to a few hundred cycles. The short timing lets the bench measure exact SCL edge spacing. It also has room to run normal frames, NACKs at the address, index and data positions, muted completions and a start request that arrives mid-frame. The bench's own slave model decodes the frames and drives the ACKs and the read data.

// File: rtl/phy_i2c_pkg.sv
package phy_i2c_pkg;

  localparam logic [15:0] OFS_DEV  = 16'h3020;
  localparam logic [15:0] OFS_REG  = 16'h3021;
  localparam logic [15:0] OFS_WHI  = 16'h3022;
  localparam logic [15:0] OFS_WLO  = 16'h3023;
  localparam logic [15:0] OFS_RHI  = 16'h3024;
  localparam logic [15:0] OFS_RLO  = 16'h3025;
  localparam logic [15:0] OFS_OP   = 16'h3026;
  localparam logic [15:0] OFS_STAT = 16'h0108;
  localparam logic [15:0] OFS_MUTE = 16'h0188;

  typedef enum logic [2:0] {
    SYM_IDLE, SYM_START, SYM_RESTART, SYM_BIT, SYM_STOP
  } sym_e;

  // SCL level for each symbol phase (four phases per symbol)
  function automatic logic scl_level(sym_e s, logic [1:0] ph);
    case (s)
      SYM_START:             return ph != 2'd3;
      SYM_RESTART, SYM_BIT:  return (ph == 2'd1) || (ph == 2'd2);
      SYM_STOP:              return ph != 2'd0;
      default:               return 1'b1;
    endcase
  endfunction

  // 1 when the master pulls SDA low
  function automatic logic sda_pull(sym_e s, logic [1:0] ph, logic bit_zero);
    case (s)
      SYM_START, SYM_RESTART: return ph >= 2'd2;
      SYM_STOP:               return ph <= 2'd1;
      SYM_BIT:                return bit_zero;
      default:                return 1'b0;
    endcase
  endfunction

  // byte sent at a given position of the frame
  function automatic logic [7:0] tx_byte(logic [2:0] idx, logic rd, logic [7:0] dev,
                                         logic [7:0] ra, logic [7:0] hi, logic [7:0] lo);
    case (idx)
      3'd0:    return {dev[6:0], 1'b0};
      3'd1:    return ra;
      3'd2:    return rd ? {dev[6:0], 1'b1} : hi;
      3'd3:    return lo;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic is_rx_byte(logic rd, logic [2:0] idx);
    return rd && (idx >= 3'd3);
  endfunction

  // symbol that follows a successfully acknowledged byte
  function automatic sym_e next_sym(logic rd, logic [2:0] idx);
    if (!rd) return (idx < 3'd3) ? SYM_BIT : SYM_STOP;
    case (idx)
      3'd1:    return SYM_RESTART;
      3'd4:    return SYM_STOP;
      default: return SYM_BIT;
    endcase
  endfunction

endpackage

// File: rtl/phy_i2c_tick.sv
module phy_i2c_tick #(
  parameter int DIV = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = en;
    end else begin : g_cnt
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            cnt <= '0;
        else if (!en || cnt == CW'(DIV - 1))   cnt <= '0;
        else                                   cnt <= cnt + 1'b1;
      end
      assign tick = en && (cnt == CW'(DIV - 1));

      p_tick_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

  p_tick_needs_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> en);
endmodule

// File: rtl/phy_i2c_seq.sv
module phy_i2c_seq
  import phy_i2c_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start_req,
  input  logic       start_rd,
  input  logic [7:0] dev,
  input  logic [7:0] ra,
  input  logic [7:0] whi,
  input  logic [7:0] wlo,
  input  logic       sda_i,
  output logic       scl_o,
  output logic       sda_oe,
  output logic       busy,
  output logic       done_p,
  output logic       err_p,
  output logic [7:0] rd_hi,
  output logic [7:0] rd_lo
);
  sym_e       sym;
  logic [1:0] phase;
  logic [3:0] bit_idx;
  logic [2:0] byte_idx;
  logic       op_rd, fail, ack_smp;
  logic [7:0] tx_sh, rx_sh;

  logic rx_byte, bit_zero, byte_end, nack_ev, cond_edge;
  sym_e after_byte;

  assign busy      = (sym != SYM_IDLE);
  assign rx_byte   = is_rx_byte(op_rd, byte_idx);
  assign bit_zero  = (bit_idx < 4'd8) ? (!rx_byte && !tx_sh[7])
                                      : (rx_byte && byte_idx == 3'd3);
  assign byte_end  = tick && phase == 2'd3 && sym == SYM_BIT && bit_idx == 4'd8;
  assign nack_ev   = byte_end && !rx_byte && ack_smp;
  assign after_byte = next_sym(op_rd, byte_idx);
  assign cond_edge = (sym == SYM_START || sym == SYM_RESTART || sym == SYM_STOP)
                     && phase == 2'd2;
  assign scl_o     = scl_level(sym, phase);
  assign sda_oe    = sda_pull(sym, phase, bit_zero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym <= SYM_IDLE; phase <= '0; bit_idx <= '0; byte_idx <= '0;
      op_rd <= 1'b0; fail <= 1'b0; ack_smp <= 1'b0;
      tx_sh <= '0; rx_sh <= '0; rd_hi <= '0; rd_lo <= '0;
      done_p <= 1'b0; err_p <= 1'b0;
    end else begin
      done_p <= 1'b0;
      err_p  <= 1'b0;
      if (sym == SYM_IDLE) begin
        if (start_req) begin
          sym <= SYM_START; phase <= '0; op_rd <= start_rd; fail <= 1'b0;
        end
      end else if (tick) begin
        phase <= phase + 1'b1;
        if (phase == 2'd2 && sym == SYM_BIT) begin
          if (bit_idx < 4'd8) rx_sh <= {rx_sh[6:0], sda_i};
          else                ack_smp <= sda_i;
        end
        if (phase == 2'd3) begin
          case (sym)
            SYM_START: begin
              sym <= SYM_BIT; bit_idx <= '0; byte_idx <= 3'd0;
              tx_sh <= tx_byte(3'd0, op_rd, dev, ra, whi, wlo);
            end
            SYM_RESTART: begin
              sym <= SYM_BIT; bit_idx <= '0; byte_idx <= 3'd2;
              tx_sh <= tx_byte(3'd2, op_rd, dev, ra, whi, wlo);
            end
            SYM_BIT: begin
              if (bit_idx != 4'd8) begin
                bit_idx <= bit_idx + 1'b1;
                tx_sh   <= {tx_sh[6:0], 1'b1};
              end else begin
                if (rx_byte && byte_idx == 3'd3) rd_hi <= rx_sh;
                if (rx_byte && byte_idx == 3'd4) rd_lo <= rx_sh;
                if (nack_ev) begin
                  fail <= 1'b1; sym <= SYM_STOP;
                end else begin
                  sym <= after_byte;
                  if (after_byte == SYM_BIT) begin
                    byte_idx <= byte_idx + 1'b1;
                    bit_idx  <= '0;
                    tx_sh    <= tx_byte(3'(byte_idx + 1'b1), op_rd, dev, ra, whi, wlo);
                  end
                end
              end
            end
            SYM_STOP: begin
              sym <= SYM_IDLE;
              if (fail) err_p  <= 1'b1;
              else      done_p <= 1'b1;
            end
            default: sym <= SYM_IDLE;
          endcase
        end
      end
    end
  end

  p_sda_moves_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scl_o) && scl_o && (sda_oe != $past(sda_oe))) |-> cond_edge);
  p_busy_keeps_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_req) |=> $stable(op_rd));
  p_nack_goes_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nack_ev |=> (sym == SYM_STOP));
endmodule

// File: rtl/phy_i2c_irq.sv
module phy_i2c_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_done,
  input  logic       set_err,
  input  logic       clr_en,
  input  logic [1:0] clr_mask,
  input  logic       mute_we,
  input  logic [1:0] mute_wd,
  output logic [1:0] stat,
  output logic [1:0] mute,
  output logic       irq
);
  logic [1:0] clr_eff;
  assign clr_eff = clr_en ? clr_mask : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      mute <= '0;
    end else begin
      stat <= (stat & ~clr_eff) | {set_done, set_err};
      if (mute_we) mute <= mute_wd;
    end
  end

  assign irq = |(stat & ~mute);

  p_done_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_done |=> stat[1]);
  p_err_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_err |=> stat[0]);
  p_clear_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && clr_mask[1] && !set_done) |=> !stat[1]);
  p_full_mute_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mute == 2'b11) |-> !irq);
endmodule

// File: rtl/phy_i2c_cmd_master.sv
module phy_i2c_cmd_master
  import phy_i2c_pkg::*;
#(
  parameter int CLK_DIV = 125
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] bus_addr,
  input  logic        bus_we,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        scl_o,
  output logic        sda_oe,
  input  logic        sda_i,
  output logic        irq
);
  logic [7:0] dev_q, reg_q, whi_q, wlo_q, rd_hi, rd_lo;
  logic [1:0] stat, mute;
  logic       busy, done_p, err_p, tick, start_req, start_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_q <= '0; reg_q <= '0; whi_q <= '0; wlo_q <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        OFS_DEV: dev_q <= bus_wdata;
        OFS_REG: reg_q <= bus_wdata;
        OFS_WHI: whi_q <= bus_wdata;
        OFS_WLO: wlo_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  // write bit wins when both operation bits are set
  assign start_req = bus_we && (bus_addr == OFS_OP) && (|bus_wdata[1:0]);
  assign start_rd  = !bus_wdata[1];

  always_comb begin
    case (bus_addr)
      OFS_DEV:  bus_rdata = dev_q;
      OFS_REG:  bus_rdata = reg_q;
      OFS_WHI:  bus_rdata = whi_q;
      OFS_WLO:  bus_rdata = wlo_q;
      OFS_RHI:  bus_rdata = rd_hi;
      OFS_RLO:  bus_rdata = rd_lo;
      OFS_STAT: bus_rdata = {6'd0, stat};
      OFS_MUTE: bus_rdata = {6'd0, mute};
      default:  bus_rdata = 8'h00;
    endcase
  end

  phy_i2c_tick #(.DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(busy), .tick(tick)
  );

  phy_i2c_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .start_req(start_req), .start_rd(start_rd),
    .dev(dev_q), .ra(reg_q), .whi(whi_q), .wlo(wlo_q),
    .sda_i(sda_i), .scl_o(scl_o), .sda_oe(sda_oe), .busy(busy),
    .done_p(done_p), .err_p(err_p), .rd_hi(rd_hi), .rd_lo(rd_lo)
  );

  phy_i2c_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set_done(done_p), .set_err(err_p),
    .clr_en(bus_we && bus_addr == OFS_STAT), .clr_mask(bus_wdata[1:0]),
    .mute_we(bus_we && bus_addr == OFS_MUTE), .mute_wd(bus_wdata[1:0]),
    .stat(stat), .mute(mute), .irq(irq)
  );

  p_outcome_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_p || err_p) |-> !busy);
  p_end_has_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done_p || err_p));
  p_irq_has_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat != 2'b00));
endmodule

// File: tb/phy_i2c_cmd_master_tb_top.sv
`timescale 1ns/1ps
module phy_i2c_cmd_master_tb_top;
  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        scl_o, sda_oe, irq;
  logic        slv_drv = 1'b0;
  wire         sda_bus = !(sda_oe || slv_drv);

  always #10 clk = ~clk;

  phy_i2c_cmd_master #(.CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .scl_o(scl_o),
    .sda_oe(sda_oe), .sda_i(sda_bus), .irq(irq)
  );

  int nchk = 0, nfail = 0, nstops = 0, stops_exp = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---------------- slave model ----------------
  bit          armed = 0;
  int          bitcnt = 0, starts = 0, nack_at = -1, rd_idx = 0;
  bit          addr_next = 0, rd_mode = 0, pend_rd = 0;
  logic [7:0]  shreg = '0;
  logic [7:0]  rd_vals [2];
  logic [7:0]  seen [$];
  logic [1:0]  mack = '0;
  int          rise_n = 0;
  time         t_rise [2];
  time         t_fall0 = 0;
  bit          fall_taken = 0;
  event        stop_ev;

  always @(negedge sda_bus) if (armed && scl_o === 1'b1) begin
    bitcnt = 0; addr_next = 1; rd_mode = 0; pend_rd = 0; slv_drv = 0;
    starts++; rise_n = 0; fall_taken = 0;
  end

  always @(posedge sda_bus) if (armed && scl_o === 1'b1) begin
    rd_mode = 0; slv_drv = 0;
    -> stop_ev;
  end

  always @(posedge scl_o) if (armed) begin
    if (rise_n < 2) begin t_rise[rise_n] = $time; rise_n++; end
    if (bitcnt < 8) begin shreg = {shreg[6:0], sda_bus}; bitcnt++; end
    else begin
      if (rd_mode) mack = {mack[0], sda_bus};
      bitcnt = 0;
    end
  end

  always @(negedge scl_o) if (armed) begin
    if (rise_n == 1 && !fall_taken) begin t_fall0 = $time; fall_taken = 1; end
    if (bitcnt == 8) begin
      if (!rd_mode) begin
        seen.push_back(shreg);
        if (addr_next && shreg[0]) pend_rd = 1;
        addr_next = 0;
        slv_drv = ((seen.size() - 1) != nack_at);
      end else slv_drv = 0;
    end else if (bitcnt == 0) begin
      if (pend_rd) begin rd_mode = 1; pend_rd = 0; rd_idx = 0; end
      else if (rd_mode) rd_idx++;
      slv_drv = (rd_mode && rd_idx < 2) ? !rd_vals[rd_idx][7] : 1'b0;
    end else if (rd_mode && rd_idx < 2) begin
      slv_drv = !rd_vals[rd_idx][7 - bitcnt];
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    int         n;
    int         nstart;
    bit         rd;
    logic [7:0] b [5];
  } exp_t;
  exp_t q [$];
  bit timing_done = 0;

  always begin
    @(stop_ev);
    nstops++;
    if (q.size() == 0) begin
      chk(0, "R9 unexpected frame", 1, 0);
    end else begin
      exp_t e;
      e = q.pop_front();
      chk(seen.size() == e.n, e.rd ? "R4 byte count" : "R3 byte count", seen.size(), e.n);
      for (int i = 0; i < e.n && i < seen.size(); i++)
        chk(seen[i] == e.b[i], e.rd ? "R4 frame byte" : "R3 frame byte", seen[i], e.b[i]);
      chk(starts == e.nstart, e.rd ? "R4 START count" : "R3 START count", starts, e.nstart);
      if (!timing_done) begin
        timing_done = 1;
        chk((t_rise[1] - t_rise[0]) == 4 * DIV * 20, "R11 bit period ns",
            int'(t_rise[1] - t_rise[0]), 4 * DIV * 20);
        chk((t_fall0 - t_rise[0]) == 2 * DIV * 20, "R11 SCL high ns",
            int'(t_fall0 - t_rise[0]), 2 * DIV * 20);
      end
    end
    seen.delete();
    starts = 0;
  end

  // ---------------- bus driver ----------------
  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_done(output logic [7:0] st);
    st = '0;
    for (int i = 0; i < 4000 && st == 8'h00; i++) begin
      repeat (5) @(negedge clk);
      bus_rd(16'h0108, st);
    end
    chk(st != 8'h00, "R5 completion seen", st, 1);
  endtask

  task automatic push_exp(input bit rd, input logic [6:0] dev, input logic [7:0] ra,
                          input logic [7:0] hi, input logic [7:0] lo, input int nk);
    exp_t e;
    e.rd = rd;
    e.b[0] = {dev, 1'b0}; e.b[1] = ra;
    e.b[2] = rd ? {dev, 1'b1} : hi;
    e.b[3] = lo; e.b[4] = 8'h00;
    if (rd) begin
      e.n = (nk >= 0) ? nk + 1 : 3;
      e.nstart = (nk >= 0 && nk < 2) ? 1 : 2;
    end else begin
      e.n = (nk >= 0) ? nk + 1 : 4;
      e.nstart = 1;
    end
    q.push_back(e);
    stops_exp++;
  endtask

  task automatic run(input bit rd, input logic [7:0] op, input logic [6:0] dev,
                     input logic [7:0] ra, input logic [7:0] hi, input logic [7:0] lo,
                     input int nk, output logic [7:0] st);
    nack_at = nk;
    push_exp(rd, dev, ra, hi, lo, nk);
    bus_wr(16'h3020, {1'b0, dev});
    bus_wr(16'h3021, ra);
    bus_wr(16'h3022, hi);
    bus_wr(16'h3023, lo);
    bus_wr(16'h3026, op);
    wait_done(st);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  // ---------------- test sequence ----------------
  initial begin
    logic [7:0] v, st;
    rd_vals[0] = 8'h5A; rd_vals[1] = 8'hC3;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    armed = 1; seen.delete(); starts = 0;

    // R1 reset state
    chk(scl_o == 1'b1, "R1 scl released", scl_o, 1);
    chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
    chk(irq == 1'b0, "R1 irq low", irq, 0);
    bus_rd(16'h0108, v); chk(v == 8'h00, "R1 status zero", v, 0);
    bus_rd(16'h0188, v); chk(v == 8'h00, "R1 mute zero", v, 0);

    // R2 register readback
    bus_wr(16'h3020, 8'h69); bus_wr(16'h3021, 8'h15);
    bus_wr(16'h3022, 8'hA7); bus_wr(16'h3023, 8'h3C);
    bus_rd(16'h3020, v); chk(v == 8'h69, "R2 device addr", v, 8'h69);
    bus_rd(16'h3021, v); chk(v == 8'h15, "R2 reg index", v, 8'h15);
    bus_rd(16'h3022, v); chk(v == 8'hA7, "R2 data high", v, 8'hA7);
    bus_rd(16'h3023, v); chk(v == 8'h3C, "R2 data low", v, 8'h3C);
    bus_rd(16'h3026, v); chk(v == 8'h00, "R2 op reads zero", v, 0);

    // R3 write, R5 done, R8 irq, R7 clearing
    run(0, 8'h02, 7'h69, 8'h15, 8'h00, 8'h0A, -1, st);
    chk(st == 8'h02, "R5 write done only", st, 8'h02);
    chk(irq == 1'b1, "R8 irq on unmuted done", irq, 1);
    bus_wr(16'h0108, 8'h00);
    bus_rd(16'h0108, v); chk(v == 8'h02, "R7 write zero keeps", v, 8'h02);
    bus_wr(16'h0108, 8'h02);
    bus_rd(16'h0108, v); chk(v == 8'h00, "R7 write one clears", v, 0);
    chk(irq == 1'b0, "R8 irq drops", irq, 0);

    // R4 read
    run(1, 8'h01, 7'h69, 8'h10, 8'h00, 8'h00, -1, st);
    chk(st == 8'h02, "R4 read done", st, 8'h02);
    bus_rd(16'h3024, v); chk(v == 8'h5A, "R4 read high", v, 8'h5A);
    bus_rd(16'h3025, v); chk(v == 8'hC3, "R4 read low", v, 8'hC3);
    chk(mack == 2'b01, "R4 master ACK then NACK", mack, 2'b01);
    bus_wr(16'h0108, 8'h03);

    // R6 NACK on address, on data, on read index
    run(0, 8'h02, 7'h33, 8'h06, 8'h12, 8'h34, 0, st);
    chk(st == 8'h01, "R6 NACK address error only", st, 8'h01);
    bus_wr(16'h0108, 8'h01);
    run(0, 8'h02, 7'h33, 8'h06, 8'h12, 8'h34, 2, st);
    chk(st == 8'h01, "R6 NACK data error only", st, 8'h01);
    bus_wr(16'h0108, 8'h01);
    run(1, 8'h01, 7'h33, 8'h09, 8'h00, 8'h00, 1, st);
    chk(st == 8'h01, "R6 NACK read index error", st, 8'h01);
    bus_wr(16'h0108, 8'h01);
    bus_rd(16'h0108, v); chk(v == 8'h00, "R7 error cleared", v, 0);

    // R8 mute
    bus_wr(16'h0188, 8'h02);
    bus_rd(16'h0188, v); chk(v == 8'h02, "R8 mute readback", v, 8'h02);
    run(0, 8'h02, 7'h21, 8'h0E, 8'h01, 8'h80, -1, st);
    chk(st == 8'h02, "R8 status set while muted", st, 8'h02);
    chk(irq == 1'b0, "R8 muted irq low", irq, 0);
    bus_wr(16'h0188, 8'h00);
    @(negedge clk); chk(irq == 1'b1, "R8 unmute raises irq", irq, 1);
    bus_wr(16'h0108, 8'h02);

    // R9 start while busy is ignored
    nack_at = -1;
    push_exp(0, 7'h44, 8'h19, 8'h80, 8'h05, -1);
    bus_wr(16'h3020, 8'h44); bus_wr(16'h3021, 8'h19);
    bus_wr(16'h3022, 8'h80); bus_wr(16'h3023, 8'h05);
    bus_wr(16'h3026, 8'h02);
    repeat (40) @(negedge clk);
    bus_wr(16'h3026, 8'h01);
    wait_done(st);
    repeat (600) @(negedge clk);
    chk(nstops == stops_exp, "R9 single frame", nstops, stops_exp);
    chk(scl_o == 1'b1 && sda_oe == 1'b0, "R9 bus idle after", {scl_o, sda_oe}, 2'b10);
    bus_rd(16'h0108, v); chk(v == 8'h02, "R9 one done", v, 8'h02);
    bus_wr(16'h0108, 8'h03);

    // R12 both op bits -> write
    run(0, 8'h03, 7'h5C, 8'h13, 8'hBE, 8'hEF, -1, st);
    chk(st == 8'h02, "R12 both bits write done", st, 8'h02);
    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R12 scoreboard drained", q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule